// File: doc/BRIEF.md
# Hierarchical Affinity Group Matcher

This block tells whether one processing element belongs to the group of elements that a 64-bit affinity descriptor names. The element is identified by a 64-bit hierarchical identifier whose four 8-bit affinity fields sit at the same bit positions as in the descriptor. The descriptor can name a single element, a whole level of the hierarchy, or a prefix-defined subset of one level.

In the level forms, the lowest nonzero byte among the three lower affinity bytes holds the marker. The value 0x80 there means the whole level one step above that byte. Any other nonzero value is a subset: its lowest set bit ends a prefix, and only the bits above that marker are compared. All affinity bytes above the marker byte are compared in full. An all-zero descriptor means the descriptor was never configured.

A request is presented with `in_valid`. One clock later the block returns a registered verdict with `out_valid`: the match, the decoded level, a subset flag, and flags for an unconfigured descriptor and a reserved encoding.

Top module: `affinity_group_match`

## Requirements
- R1: `out_valid` is high exactly in the cycle after an `in_valid` cycle. Between requests, the result outputs keep the last verdict.
- R2: A synchronous active-high `rst` clears every output to zero on the next clock edge.
- R3: A descriptor that is all zeros gives `unconfigured`=1, `match`=0, `level`=0 and `subset`=0.
- R4: When descriptor bit 31 is 1, the descriptor names one element, giving `level`=0 and `subset`=0. A match then needs four things to equal the identifier exactly: bits [39:32], bits [23:16], bits [15:8] and bits [7:0]. It also needs bit 30 and bit 24 to equal the identifier.
- R5: When bit 31 is 0 and the lowest nonzero byte j (byte 0=[7:0], 1=[15:8], 2=[23:16]) equals 0x80, the block reports `level`=j+1 and `subset`=0. Only the affinity bytes above byte j are compared, each in full.
- R6: When bit 31 is 0 and the lowest nonzero byte j is not 0x80, let k be its lowest set bit. Then only bits [7:k+1] of byte j are compared with the identifier, and the bytes above j are compared in full. The block reports `level`=j and `subset`=1.
- R7: When [23:16]=0x80 and [15:0]=0 with bit 31 at 0, the block reports `level`=3, and only [39:32] decides the match.
- R8: The following bits never change the verdict: descriptor bits 30 and 24 while bit 31 is 0, and identifier bits outside [39:32], [30], [24] and [23:0].
- R9: A descriptor is reserved when it is nonzero and meets any one of these conditions: a set bit in [63:40], a set bit in [29:25], or bit 31 at 0 with [23:0] all zero. A reserved descriptor gives `reserved`=1, `match`=0, `level`=0 and `subset`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| desc_i | input | 64 | Affinity descriptor |
| pe_id_i | input | 64 | Hierarchical identifier of the element |
| out_valid | output | 1 | Verdict strobe, one cycle after the request |
| match_o | output | 1 | Element belongs to the named group |
| level_o | output | 2 | Decoded affinity level 0..3 |
| subset_o | output | 1 | Level is a prefix subset |
| unconfigured_o | output | 1 | Descriptor is all zeros |
| reserved_o | output | 1 | Descriptor uses a reserved encoding |

## Verification
Two decisions can land in the same cycle: the reserved-encoding check and the prefix or full comparison. A descriptor whose affinity bytes would match the identifier perfectly can still carry a stray reserved bit in [63:40] or [29:25]. The bench sends exactly such descriptors, back to back with legal ones that do match. It expects `reserved` to win, so the bench expects `match` low, `level` zero and no subset flag in that same result beat.

// File: rtl/afm_pkg.sv
package afm_pkg;
  localparam int unsigned AFF_W    = 8;
  localparam int unsigned LVL_N    = 4;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned LVL_W    = $clog2(LVL_N);
  localparam int unsigned ELEM_BIT = 31;
  localparam int unsigned UNI_BIT  = 30;
  localparam int unsigned MT_BIT   = 24;
  localparam logic [AFF_W-1:0] WHOLE_MARK = {1'b1, {(AFF_W-1){1'b0}}};

  // least significant bit of affinity byte i inside the 64-bit word
  function automatic int unsigned aff_lsb(input int unsigned i);
    return (i == LVL_N - 1) ? 32 : AFF_W * i;
  endfunction

  typedef struct packed {
    logic             match;
    logic             unconf;
    logic             rsvd;
    logic             subset;
    logic [LVL_W-1:0] level;
  } verdict_t;
endpackage

// File: rtl/afm_byte_cmp.sv
module afm_byte_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_byte,
  input  logic [W-1:0] id_byte,
  output logic         full_eq,
  output logic         pref_eq
);
  logic [W-1:0] keep_mask;

  // bits at and below the lowest set bit are dropped from the compare
  always_comb begin
    keep_mask = ~(d_byte ^ (d_byte - W'(1)));
    full_eq   = (d_byte == id_byte);
    pref_eq   = (((d_byte ^ id_byte) & keep_mask) == '0);
  end
endmodule

// File: rtl/afm_mode_decode.sv
module afm_mode_decode
  import afm_pkg::*;
(
  input  logic [WORD_W-1:0] desc,
  output logic [LVL_N-1:0]  need_full,
  output logic [LVL_N-1:0]  need_pref,
  output logic              check_um,
  output logic [LVL_W-1:0]  level,
  output logic              subset,
  output logic              unconf,
  output logic              rsvd
);
  logic [AFF_W-1:0] aff [LVL_N];
  logic [LVL_N-2:0] nz;
  logic [LVL_W-1:0] sel;
  logic             sel_whole;
  logic             bad_bits;

  for (genvar g = 0; g < LVL_N; g++) begin : g_split
    assign aff[g] = desc[aff_lsb(g) +: AFF_W];
  end
  for (genvar g = 0; g < LVL_N - 1; g++) begin : g_nz
    assign nz[g] = |aff[g];
  end

  assign bad_bits = (|desc[WORD_W-1:40]) | (|desc[29:25]);

  always_comb begin
    sel = '0;
    for (int j = LVL_N - 2; j >= 0; j--) begin
      if (nz[j]) sel = LVL_W'(j);
    end
    sel_whole = (aff[sel] == WHOLE_MARK);
  end

  always_comb begin
    need_full = '0;
    need_pref = '0;
    check_um  = 1'b0;
    level     = '0;
    subset    = 1'b0;
    unconf    = 1'b0;
    rsvd      = 1'b0;
    if (desc == '0) begin
      unconf = 1'b1;
    end else if (bad_bits) begin
      rsvd = 1'b1;
    end else if (desc[ELEM_BIT]) begin
      need_full = '1;
      check_um  = 1'b1;
    end else if (nz == '0) begin
      rsvd = 1'b1;
    end else begin
      for (int i = 0; i < LVL_N; i++) begin
        need_full[i] = (i > int'(sel));
      end
      if (sel_whole) begin
        level = sel + LVL_W'(1);
      end else begin
        level          = sel;
        subset         = 1'b1;
        need_pref[sel] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/affinity_group_match.sv
module affinity_group_match
  import afm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0] pe_id_i,
  output logic              out_valid,
  output logic              match_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              subset_o,
  output logic              unconfigured_o,
  output logic              reserved_o
);
  logic [LVL_N-1:0] full_eq, pref_eq, need_full, need_pref;
  logic             check_um, subset_c, unconf_c, rsvd_c, um_ok, hit_c;
  logic [LVL_W-1:0] level_c;
  verdict_t         res_q;

  for (genvar g = 0; g < LVL_N; g++) begin : g_cmp
    afm_byte_cmp #(.W(AFF_W)) u_cmp (
      .d_byte  (desc_i[aff_lsb(g) +: AFF_W]),
      .id_byte (pe_id_i[aff_lsb(g) +: AFF_W]),
      .full_eq (full_eq[g]),
      .pref_eq (pref_eq[g])
    );
  end

  afm_mode_decode u_dec (
    .desc      (desc_i),
    .need_full (need_full),
    .need_pref (need_pref),
    .check_um  (check_um),
    .level     (level_c),
    .subset    (subset_c),
    .unconf    (unconf_c),
    .rsvd      (rsvd_c)
  );

  assign um_ok = !check_um ||
                 (desc_i[UNI_BIT] == pe_id_i[UNI_BIT] && desc_i[MT_BIT] == pe_id_i[MT_BIT]);
  assign hit_c = !unconf_c && !rsvd_c && um_ok &&
                 (&(~need_full | full_eq)) && (&(~need_pref | pref_eq));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_q.match  <= hit_c;
        res_q.unconf <= unconf_c;
        res_q.rsvd   <= rsvd_c;
        res_q.subset <= subset_c;
        res_q.level  <= level_c;
      end
    end
  end

  assign match_o        = res_q.match;
  assign level_o        = res_q.level;
  assign subset_o       = res_q.subset;
  assign unconfigured_o = res_q.unconf;
  assign reserved_o     = res_q.rsvd;
endmodule

// File: rtl/affinity_group_match_chk.sv
module affinity_group_match_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] desc_i,
  input logic [63:0] pe_id_i,
  input logic        out_valid,
  input logic        match_o,
  input logic [1:0]  level_o,
  input logic        subset_o,
  input logic        unconfigured_o,
  input logic        reserved_o
);
  logic legal_hi;
  assign legal_hi = (desc_i[63:40] == '0) && (desc_i[29:25] == '0);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(match_o) && $stable(level_o) && $stable(subset_o));
  p_unconf_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && desc_i == '0 |=> unconfigured_o && !match_o);
  p_elem_miss_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal_hi && desc_i[31] && desc_i[39:32] != pe_id_i[39:32] |=> !match_o);
  p_subset_level_r6: assert property (@(posedge clk) disable iff (rst)
    subset_o |-> level_o != 2'd3);
  p_top_level_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal_hi && !desc_i[31] && desc_i[23:0] == 24'h800000 |=> level_o == 2'd3 && !subset_o);
  p_rsvd_nomatch_r9: assert property (@(posedge clk) disable iff (rst)
    reserved_o |-> !match_o && !subset_o && level_o == 2'd0);
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({match_o, reserved_o, unconfigured_o}));
endmodule

bind affinity_group_match affinity_group_match_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .desc_i         (desc_i),
  .pe_id_i        (pe_id_i),
  .out_valid      (out_valid),
  .match_o        (match_o),
  .level_o        (level_o),
  .subset_o       (subset_o),
  .unconfigured_o (unconfigured_o),
  .reserved_o     (reserved_o)
);

// File: tb/affinity_group_match_tb.sv
module affinity_group_match_tb;
  typedef struct packed {
    logic       m;
    logic       unc;
    logic       rsv;
    logic       sub;
    logic [1:0] lvl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] desc_i = '0;
  logic [63:0] pe_id_i = '0;
  logic        out_valid, match_o, subset_o, unconfigured_o, reserved_o;
  logic [1:0]  level_o;

  int total = 0;
  int bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  localparam logic [63:0] ID0 = 64'hDEAD00A5_7E3C1234;

  always #5 clk = ~clk;

  affinity_group_match u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .desc_i(desc_i), .pe_id_i(pe_id_i),
    .out_valid(out_valid), .match_o(match_o), .level_o(level_o), .subset_o(subset_o),
    .unconfigured_o(unconfigured_o), .reserved_o(reserved_o)
  );

  function automatic logic [7:0] byte_of(input logic [63:0] v, input int i);
    return (i == 3) ? v[39:32] : v[8*i +: 8];
  endfunction

  function automatic exp_t model(input logic [63:0] d, input logic [63:0] id);
    exp_t e;
    int   j;
    int   k;
    logic [7:0] b;
    logic ok;
    e = '0;
    if (d == 64'd0) begin
      e.unc = 1'b1;
      return e;
    end
    if (d[63:40] != 0 || d[29:25] != 0 || (!d[31] && d[23:0] == 0)) begin
      e.rsv = 1'b1;
      return e;
    end
    if (d[31]) begin
      ok = (d[30] == id[30]) && (d[24] == id[24]);
      for (int i = 0; i < 4; i++) if (byte_of(d, i) != byte_of(id, i)) ok = 1'b0;
      e.m = ok;
      return e;
    end
    j = 2;
    for (int i = 2; i >= 0; i--) if (byte_of(d, i) != 0) j = i;
    b  = byte_of(d, j);
    ok = 1'b1;
    for (int i = j + 1; i < 4; i++) if (byte_of(d, i) != byte_of(id, i)) ok = 1'b0;
    if (b == 8'h80) begin
      e.lvl = 2'(j + 1);
    end else begin
      k = 0;
      for (int i = 7; i >= 0; i--) if (b[i]) k = i;
      if ((b >> (k + 1)) != (byte_of(id, j) >> (k + 1))) ok = 1'b0;
      e.lvl = 2'(j);
      e.sub = 1'b1;
    end
    e.m = ok;
    return e;
  endfunction

  task automatic send(input logic [63:0] d, input logic [63:0] id, input string tag);
    @(negedge clk);
    desc_i   = d;
    pe_id_i  = id;
    in_valid = 1'b1;
    exp_q.push_back(model(d, id));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the expected verdict whenever one comes out
  always @(negedge clk) begin
    exp_t  e;
    string t;
    if (!rst && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1: out_valid=1 expected 0 (no pending request)");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({match_o, unconfigured_o, reserved_o, subset_o, level_o} !== e) begin
          bad++;
          $display("FAIL %s: got m=%0b unc=%0b rsv=%0b sub=%0b lvl=%0d expected m=%0b unc=%0b rsv=%0b sub=%0b lvl=%0d",
                   t, match_o, unconfigured_o, reserved_o, subset_o, level_o,
                   e.m, e.unc, e.rsv, e.sub, e.lvl);
        end
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({out_valid, match_o, level_o, subset_o, unconfigured_o, reserved_o} !== 7'b0) begin
      bad++;
      $display("FAIL R2: outputs=%b expected 0000000",
               {out_valid, match_o, level_o, subset_o, unconfigured_o, reserved_o});
    end
    rst = 1'b0;

    send(64'h0, ID0, "R3 all-zero descriptor");
    send(64'h000000A5_C03C1234, ID0, "R4 exact element");
    send(64'h000000A5_C03C1235, ID0, "R4 element aff0 differs");
    send(64'h000000A5_C13C1234, ID0, "R4 element MT differs");
    send(64'h000000A5_803C1234, ID0, "R4 element U differs");
    send(64'h000000A5_003C1280, ID0, "R5 whole level1");
    send(64'h000000A5_003C8000, ID0, "R5 whole level2");
    send(64'h000000A5_003D8000, ID0, "R5 whole level2 aff2 differs");
    idle(2);
    send(64'h000000A5_00800000, ID0, "R7 level3 match");
    send(64'h000000A6_00800000, ID0, "R7 level3 aff3 differs");
    send(64'h000000A5_003C1238, ID0, "R6 subset aff0 k=3");
    send(64'h000000A5_003C1248, ID0, "R6 subset aff0 prefix differs");
    send(64'h000000A5_003C1300, ID0, "R6 subset aff1 k=0");
    send(64'h000000A5_00400000, ID0, "R6 subset aff2 k=6");
    send(64'h000000A5_00C00000, ID0, "R6 subset aff2 top bit differs");
    send(64'h000000A5_413C1280, ID0, "R8 U/MT ignored");
    send(64'h000000A5_003C1280, 64'h123400A5_803C1299, "R8 id extra bits ignored");
    send(64'h000001A5_003C1280, ID0, "R9 high reserved bit");
    send(64'h000000A5_023C1280, ID0, "R9 mid reserved bit");
    send(64'h000000A5_00000000, ID0, "R9 no marker");
    send(64'h000000A5_003C1280, ID0, "R5 whole level1 after reserved");
    idle(4);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1: pending=%0d expected 0", exp_q.size());
    end
    total++;
    if (out_valid !== 1'b0 || match_o !== 1'b1 || level_o !== 2'd1) begin
      bad++;
      $display("FAIL R1: hold v=%0b m=%0b lvl=%0d expected v=0 m=1 lvl=1",
               out_valid, match_o, level_o);
    end
    rst = 1'b1;
    @(negedge clk);
    total++;
    if ({out_valid, match_o, level_o, subset_o, unconfigured_o, reserved_o} !== 7'b0) begin
      bad++;
      $display("FAIL R2: outputs=%b expected 0000000",
               {out_valid, match_o, level_o, subset_o, unconfigured_o, reserved_o});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule